// File: doc/BRIEF.md
# Pipelined Two-Phase Bus Master

This block is a clocked bus master. It takes read and write commands from a valid/ready command port and runs each one as a transfer on a pipelined bus. Every transfer has two phases. The address phase uses a request/acknowledge handshake on the address lines. The data phase is paced by a data-ready strobe from the target. Both handshakes are complete four-edge exchanges.

The two phases are separate pipeline stages, and each stage holds at most one transfer. A short in-order queue sits between them. As soon as one transfer finishes its address phase, the next transfer can start its own address phase while the first is still in its data phase. Data phases run in the same order as address phases, so read results come back in command order. Each read result appears on the response port for a single cycle; writes produce no response.

Top module: `twophase_bus_master`

## Requirements
- R1: While `rst_n` is low, from the first clock edge onward, `bus_addr_req`, `bus_data_oe` and `rsp_valid` are 0 and `cmd_ready` is 1. Reset clears both phase engines and the pending queue.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle `bus_addr_req` is 1, `bus_addr` carries the command address and `bus_dir` carries the direction (1 = write, 0 = read). All three stay unchanged until the clock edge that samples `bus_addr_ack` high.
- R3: `bus_addr_req` is 0 in the cycle after the edge that samples `bus_addr_ack` high. The address phase ends on the edge that then samples `bus_addr_ack` low.
- R4: `cmd_ready` is 0 for the whole address phase, so the bus carries at most one address transfer at a time.
- R5: For a read, `bus_rdata` is sampled on the edge where `bus_data_rdy` is first seen high in that data phase. That value is later presented on `rsp_data`.
- R6: `rsp_valid` is 1 for exactly one cycle per read: the cycle after the edge that samples `bus_data_rdy` low at the end of the read's data phase. It is never 1 at any other time.
- R7: For a write, `bus_data_oe` is 1 and `bus_wdata` holds the command's write data from the start of the data phase through the edge that samples `bus_data_rdy` low. A write produces no response. `bus_data_oe` stays 0 during a read's data phase.
- R8: Once a transfer's address phase has ended, a new command can be accepted and its address phase can run while the earlier data phase is still pending.
- R9: Data phases, and therefore read responses, complete in the same order in which commands were accepted.
- R10: At most QUEUE_DEPTH transfers wait between the stages. With the target holding every data phase, exactly QUEUE_DEPTH+1 commands are accepted (one in the data stage, QUEUE_DEPTH queued), and after that `cmd_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | DATA_W | Read result |
| bus_dir | output | 1 | Direction of the transfer in its address phase |
| bus_addr | output | ADDR_W | Address bus |
| bus_addr_req | output | 1 | Address request |
| bus_addr_ack | input | 1 | Address acknowledge from the target |
| bus_data_rdy | input | 1 | Data-ready strobe from the target |
| bus_rdata | input | DATA_W | Data bus, target to master |
| bus_wdata | output | DATA_W | Data bus, master to target |
| bus_data_oe | output | 1 | Master is driving `bus_wdata` |

## Verification
- **Address phase:** `bus_addr_req` must be high, with the command's address and direction, at the first falling edge after the accepting rising edge. It must be low one falling edge after the bench's target raises the acknowledge. The bench checks at exactly those points.
- **Data phase:** the target model raises data-ready only when the data stage is certain to be waiting, which is two cycles after the address phase ends and two cycles after the previous data phase ends.
  - Write data and its enable are checked when data-ready rises and again when it falls.
  - The matching `rsp_valid` and `rsp_data` are expected at exactly one falling edge after data-ready drops.
  - A response strobe in any other cycle is reported as an error.
- **Sweep:** covers every combination of acknowledge delay, data-ready delay and data-ready hold time in a small range, each with a different read/write mix.
- **Stall test:** holds the data phase indefinitely to count how many commands are accepted.

// File: rtl/tbm_pkg.sv
// Package: shared state encodings for the pipelined two-phase bus master.
// Assumes: nothing beyond the types declared here.
package tbm_pkg;

    // Address phase engine states.
    typedef enum logic [1:0] {
        ADDR_IDLE    = 2'd0,
        ADDR_REQ     = 2'd1,
        ADDR_RELEASE = 2'd2
    } addr_phase_e;

    // Data phase engine states.
    typedef enum logic [1:0] {
        DATA_IDLE    = 2'd0,
        DATA_WAIT_HI = 2'd1,
        DATA_WAIT_LO = 2'd2
    } data_phase_e;

endpackage

// File: rtl/tbm_addr_stage.sv
// Module: address phase engine. It accepts one command at a time, runs the
// request/acknowledge handshake, and pushes the transfer into the pending
// queue once the acknowledge has fallen again.
// Assumes: the queue's full flag covers every push (only this stage pushes,
// and it accepts a command only while the queue has room).
module tbm_addr_stage
    import tbm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    input  logic              q_full,
    output logic              bus_dir,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_req,
    input  logic              bus_addr_ack,
    output logic              push,
    output logic              push_write,
    output logic [DATA_W-1:0] push_wdata
);

    addr_phase_e       state_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    // Accept only when idle and there is room for the transfer later on.
    assign cmd_ready = (state_q == ADDR_IDLE) && !q_full;
    assign accept    = cmd_valid && cmd_ready;

    // Four-edge handshake sequencing for the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ADDR_IDLE;
        end else begin
            unique case (state_q)
                ADDR_IDLE:    if (accept)        state_q <= ADDR_REQ;
                ADDR_REQ:     if (bus_addr_ack)  state_q <= ADDR_RELEASE;
                ADDR_RELEASE: if (!bus_addr_ack) state_q <= ADDR_IDLE;
                default:                         state_q <= ADDR_IDLE;
            endcase
        end
    end

    // Capture the accepted command; held for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= cmd_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    assign bus_addr_req = (state_q == ADDR_REQ);
    assign bus_addr     = addr_q;
    assign bus_dir      = write_q;

    // Hand the transfer to the data side when the acknowledge has dropped.
    assign push       = (state_q == ADDR_RELEASE) && !bus_addr_ack;
    assign push_write = write_q;
    assign push_wdata = wdata_q;

endmodule

// File: rtl/tbm_order_queue.sv
// Module: first-in first-out queue of transfers whose address phase is done
// and whose data phase has not started yet.
// Assumes: push is never raised while full, and pop is never raised while empty.
module tbm_order_queue #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0] slot_we;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    // One write enable per slot, selected by the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
        assign slot_we[i] = push && (wr_ptr_q == PTR_W'(i));
    end

    // Slot storage.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) slot_q[i] <= push_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            unique case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_data = slot_q[rd_ptr_q];
    assign full      = (count_q == CNT_W'(DEPTH));
    assign empty     = (count_q == '0);

endmodule

// File: rtl/tbm_data_stage.sv
// Module: data phase engine. It takes the oldest pending transfer, drives
// write data or captures read data around the data-ready strobe, and emits
// a one-cycle response for reads once the strobe has fallen.
// Assumes: the target raises data-ready only for a transfer whose address
// phase has finished, and keeps it high until the stage has seen it.
module tbm_data_stage
    import tbm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  logic              head_write,
    input  logic [DATA_W-1:0] head_wdata,
    output logic              pop,
    input  logic              bus_data_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    data_phase_e       state_q;
    logic              cur_write_q;
    logic [DATA_W-1:0] cur_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;
    logic              finish;

    assign pop    = (state_q == DATA_IDLE) && !q_empty;
    assign finish = (state_q == DATA_WAIT_LO) && !bus_data_rdy;

    // Data phase sequencing: wait for the strobe to rise, then to fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DATA_IDLE;
        end else begin
            unique case (state_q)
                DATA_IDLE:    if (!q_empty)     state_q <= DATA_WAIT_HI;
                DATA_WAIT_HI: if (bus_data_rdy) state_q <= DATA_WAIT_LO;
                DATA_WAIT_LO: if (!bus_data_rdy) state_q <= DATA_IDLE;
                default:                        state_q <= DATA_IDLE;
            endcase
        end
    end

    // Load the transfer being served from the queue head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write_q <= 1'b0;
            cur_wdata_q <= '0;
        end else if (pop) begin
            cur_write_q <= head_write;
            cur_wdata_q <= head_wdata;
        end
    end

    // Sample read data on the edge that first sees data-ready high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if ((state_q == DATA_WAIT_HI) && bus_data_rdy && !cur_write_q) begin
            rdata_q <= bus_rdata;
        end
    end

    // One-cycle response strobe for reads after the strobe has fallen.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= 1'b0;
        else        rsp_q <= finish && !cur_write_q;
    end

    assign bus_data_oe = (state_q != DATA_IDLE) && cur_write_q;
    assign bus_wdata   = cur_wdata_q;
    assign rsp_valid   = rsp_q;
    assign rsp_data    = rdata_q;

endmodule

// File: rtl/twophase_bus_master.sv
// Module: top of the pipelined two-phase bus master. It links the address
// engine, the in-order pending queue and the data engine, so one transfer's
// address phase can overlap another transfer's data phase.
// Assumes: a single target that completes data phases in address order.
module twophase_bus_master #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int QUEUE_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_dir,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_req,
    input  logic              bus_addr_ack,
    input  logic              bus_data_rdy,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe
);

    localparam int ENTRY_W = 1 + DATA_W;

    logic               q_full;
    logic               q_empty;
    logic               q_push;
    logic               q_pop;
    logic               push_write;
    logic [DATA_W-1:0]  push_wdata;
    logic [ENTRY_W-1:0] head_entry;

    // Address phase stage.
    tbm_addr_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_write    (cmd_write),
        .cmd_addr     (cmd_addr),
        .cmd_wdata    (cmd_wdata),
        .cmd_ready    (cmd_ready),
        .q_full       (q_full),
        .bus_dir      (bus_dir),
        .bus_addr     (bus_addr),
        .bus_addr_req (bus_addr_req),
        .bus_addr_ack (bus_addr_ack),
        .push         (q_push),
        .push_write   (push_write),
        .push_wdata   (push_wdata)
    );

    // Pending transfers between the stages.
    tbm_order_queue #(
        .WIDTH (ENTRY_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({push_write, push_wdata}),
        .pop       (q_pop),
        .head_data (head_entry),
        .full      (q_full),
        .empty     (q_empty)
    );

    // Data phase stage.
    tbm_data_stage #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_empty      (q_empty),
        .head_write   (head_entry[ENTRY_W-1]),
        .head_wdata   (head_entry[DATA_W-1:0]),
        .pop          (q_pop),
        .bus_data_rdy (bus_data_rdy),
        .bus_rdata    (bus_rdata),
        .bus_wdata    (bus_wdata),
        .bus_data_oe  (bus_data_oe),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data)
    );

endmodule

// File: rtl/tbm_checker.sv
// Module: protocol checker bound to the bus master top. It watches only
// port-level behaviour.
// Assumes: rst_n is the synchronous active-low reset of the top.
module tbm_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              bus_addr_req,
    input logic              bus_addr_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_dir,
    input logic              bus_data_rdy,
    input logic              bus_data_oe,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rsp_valid
);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_req && !bus_addr_ack) |=> (bus_addr_req && $stable(bus_addr) && $stable(bus_dir)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_req && bus_addr_ack) |=> !bus_addr_req);

    // R4
    single_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_req |-> !cmd_ready);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    rsp_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!bus_data_rdy));

    // R7
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_wdata));

    // R7
    no_write_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_data_oe);

endmodule

bind twophase_bus_master tbm_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_tbm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .bus_addr_req (bus_addr_req),
    .bus_addr_ack (bus_addr_ack),
    .bus_addr     (bus_addr),
    .bus_dir      (bus_dir),
    .bus_data_rdy (bus_data_rdy),
    .bus_data_oe  (bus_data_oe),
    .bus_wdata    (bus_wdata),
    .rsp_valid    (rsp_valid)
);

// File: tb/twophase_bus_master_bench.sv
`timescale 1ns/1ps
// Bench: sweeps target timing over a small range, models the bus target,
// and checks every phase edge and response cycle against values worked out
// from the requirements.
module twophase_bus_master_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_ready;
    logic       cmd_write;
    logic [7:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       bus_dir;
    logic [7:0] bus_addr;
    logic       bus_addr_req;
    logic       ack;
    logic       rdy;
    logic [7:0] rdata;
    logic [7:0] bus_wdata;
    logic       bus_data_oe;

    always #2.5 clk = ~clk;

    twophase_bus_master u_twophase_bus_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_write    (cmd_write),
        .cmd_addr     (cmd_addr),
        .cmd_wdata    (cmd_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .bus_dir      (bus_dir),
        .bus_addr     (bus_addr),
        .bus_addr_req (bus_addr_req),
        .bus_addr_ack (ack),
        .bus_data_rdy (rdy),
        .bus_rdata    (rdata),
        .bus_wdata    (bus_wdata),
        .bus_data_oe  (bus_data_oe)
    );

    // Scoreboard and configuration (written by the driver only).
    bit         cw [256];
    logic [7:0] ca [256];
    logic [7:0] cd [256];
    int         n_acc;
    int         a_dly, d_dly, d_hold;
    bit         stall;
    int         drv_checks = 0, drv_errors = 0;

    // Target model state (written by the monitor only).
    int         mon_checks = 0, mon_errors = 0;
    int         a_st, a_cnt, a_idx, d_st, d_cnt, d_idx;
    int         elig_cyc [256];
    int         last_fall, rsp_chk_cyc;
    bit         rsp_exp_v;
    logic [7:0] rsp_exp_d;
    int         n_rsp, n_reads, n_ovl;
    int         cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] rd_fn(input logic [7:0] a);
        return {a[2:0], a[7:3]} ^ 8'h5A;
    endfunction

    task automatic chk_d(input bit ok, input string req, input string what, input int act, input int exp);
        drv_checks++;
        if (!ok) begin
            drv_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_m(input bit ok, input string req, input string what, input int act, input int exp);
        mon_checks++;
        if (!ok) begin
            mon_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bus target model and response monitor, all on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ack = 1'b0; rdy = 1'b0; rdata = 8'h00;
            a_st = 0; a_cnt = 0; a_idx = 0;
            d_st = 0; d_cnt = 0; d_idx = 0;
            last_fall = -10; rsp_chk_cyc = -1; rsp_exp_v = 1'b0; rsp_exp_d = 8'h00;
            n_rsp = 0; n_reads = 0; n_ovl = 0;
        end else begin
            // R6 / R5 / R9: response exactly one falling edge after data-ready drops
            if (cyc == rsp_chk_cyc) begin
                chk_m(rsp_valid == rsp_exp_v, "R6", "rsp_valid after strobe fall", rsp_valid, rsp_exp_v);
                if (rsp_exp_v)
                    chk_m(rsp_data == rsp_exp_d, "R5 R9", "read data in order", rsp_data, rsp_exp_d);
            end else if (rsp_valid) begin
                chk_m(1'b0, "R6", "unexpected rsp_valid", 1, 0);
            end
            if (rsp_valid) n_rsp++;
            if (bus_addr_req && (rdy || bus_data_oe)) n_ovl++;

            // Address side of the target
            case (a_st)
                0: if (bus_addr_req) begin
                    if (a_cnt >= a_dly) begin
                        chk_m(bus_addr == ca[a_idx], "R2", "address order", bus_addr, ca[a_idx]);
                        chk_m(bus_dir == cw[a_idx], "R2", "direction", bus_dir, cw[a_idx]);
                        ack = 1'b1; a_st = 1; a_cnt = 0;
                    end else a_cnt++;
                end
                default: begin
                    chk_m(!bus_addr_req, "R3", "request dropped after ack", bus_addr_req, 0);
                    if (a_cnt >= a_dly) begin
                        ack = 1'b0; elig_cyc[a_idx] = cyc; a_idx++; a_st = 0; a_cnt = 0;
                    end else a_cnt++;
                end
            endcase

            // Data side of the target
            case (d_st)
                0: if (!stall && d_idx < a_idx && cyc >= elig_cyc[d_idx] + 2 + d_dly
                       && cyc >= last_fall + 2) begin
                    if (cw[d_idx]) begin
                        chk_m(bus_data_oe == 1'b1, "R7", "write enable at rise", bus_data_oe, 1);
                        chk_m(bus_wdata == cd[d_idx], "R7", "write data at rise", bus_wdata, cd[d_idx]);
                    end else begin
                        chk_m(bus_data_oe == 1'b0, "R7", "no drive on read", bus_data_oe, 0);
                    end
                    rdata = rd_fn(ca[d_idx]); rdy = 1'b1; d_st = 1; d_cnt = 0;
                end
                default: begin
                    if (d_cnt + 1 >= d_hold) begin
                        if (cw[d_idx]) begin
                            chk_m(bus_data_oe == 1'b1, "R7", "write enable at fall", bus_data_oe, 1);
                            chk_m(bus_wdata == cd[d_idx], "R7", "write data at fall", bus_wdata, cd[d_idx]);
                        end else n_reads++;
                        rsp_chk_cyc = cyc + 1;
                        rsp_exp_v = !cw[d_idx];
                        rsp_exp_d = rd_fn(ca[d_idx]);
                        rdy = 1'b0; rdata = 8'h00; last_fall = cyc; d_idx++; d_st = 0;
                    end else d_cnt++;
                end
            endcase
        end
    end

    // Offer one command; called on a falling edge, returns on a falling edge.
    task automatic send(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input int maxw, output bit ok);
        bit r;
        cw[n_acc] = w; ca[n_acc] = a; cd[n_acc] = d;
        cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        ok = 1'b0;
        for (int i = 0; i < maxw; i++) begin
            r = cmd_ready;
            @(negedge clk);
            if (r) begin ok = 1'b1; break; end
        end
        cmd_valid = 1'b0;
        if (ok) begin
            n_acc++;
            chk_d(bus_addr_req && bus_addr == a, "R2", "request with address after accept", bus_addr, a);
            chk_d(!cmd_ready, "R4", "not ready during address phase", cmd_ready, 0);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 2000; i++) begin
            if (d_idx == n_acc) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk_d(d_idx == n_acc, "R9", "all data phases done", d_idx, n_acc);
    endtask

    task automatic reset_checks();
        chk_d(bus_addr_req == 1'b0, "R1", "addr_req in reset", bus_addr_req, 0);
        chk_d(bus_data_oe == 1'b0, "R1", "data_oe in reset", bus_data_oe, 0);
        chk_d(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        chk_d(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
    endtask

    task automatic summary(input int extra);
        $display("Simulation finished: %0d checks, %0d errors",
                 drv_checks + mon_checks + extra, drv_errors + mon_errors + extra);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary(1);
        $finish;
    end

    initial begin
        bit ok;
        int acc;
        int cfg;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = 8'h00; cmd_wdata = 8'h00;
        stall = 1'b0; a_dly = 0; d_dly = 0; d_hold = 1; n_acc = 0;
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of target timing with varying read/write mixes
        cfg = 0;
        for (int ad = 0; ad < 3; ad++) begin
            for (int dd = 0; dd < 3; dd++) begin
                for (int h = 1; h < 3; h++) begin
                    a_dly = ad; d_dly = dd; d_hold = h;
                    for (int k = 0; k < 6; k++) begin
                        send(((cfg + k) % 3) == 0, 8'((cfg * 37 + k * 53) & 255),
                             8'(((cfg * 11 + k * 29) & 255) ^ 8'hC3), 200, ok);
                        chk_d(ok, "R8", "command accepted", ok, 1);
                    end
                    drain();
                    cfg++;
                end
            end
        end
        chk_d(n_ovl > 0, "R8", "address phase overlapped data phase", n_ovl, 1);
        chk_d(n_rsp == n_reads, "R9", "one response per read", n_rsp, n_reads);

        // Stalled data phase: queue fills, ready stays low
        stall = 1'b1; a_dly = 0; d_dly = 0; d_hold = 1;
        acc = 0;
        for (int k = 0; k < 4; k++) begin
            send(k[0], 8'(16 + k), 8'(100 + k), 40, ok);
            if (ok) acc++;
        end
        chk_d(acc == 3, "R10", "accepted while data held", acc, 3);
        chk_d(cmd_ready == 1'b0, "R10", "ready low when queue full", cmd_ready, 0);

        // Reset with the queue full
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_checks();
        n_acc = 0; stall = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        send(1'b0, 8'h3E, 8'h00, 50, ok);
        send(1'b1, 8'h81, 8'hE7, 50, ok);
        send(1'b0, 8'hFF, 8'h00, 50, ok);
        drain();
        chk_d(n_rsp == 2, "R9", "responses after reset", n_rsp, 2);

        summary(0);
        $finish;
    end

endmodule